// File: doc/BRIEF.md
# Multi-Core Shared Memory Write Fabric

This block connects sixteen processor cores to the second write port of sixteen per-core lookup memories of 512 words by 32 bits. Each core holds a 16-bit target mask. Bit t of the mask means memory t. A single write request from a core is copied to every memory whose bit is set in that mask, and each copy goes to the same address. A core's own memory is a legal target. Each memory has no arbiter. Every core registers its request onto a private bus of one enable bit, 9 address bits and 32 data bits. At each memory, the buses are gated by the mask bit that addresses that memory and then merged bitwise with AND-OR. Writer/target pairs that do not share a target therefore all proceed on the same clock.

Writes come in two kinds. A fast write reaches the memory on the edge after the request is captured. If two fast writes hit one memory on the same clock, their addresses and data are ORed together and nothing flags it. A shared write waits for the core's turn on a free-running slot counter. It lands between 1 and 16 edges after capture and never collides with another shared write. While a shared write waits, the core reports busy and ignores new requests. Each memory raises a one-cycle event flag for every write it accepts. The flag does not say which core wrote. A registered read port per memory stands in for the first port so the memory contents can be observed.

Top module: `lutfab_top`

## Requirements
- R1: After reset every mask is zero, busy is low and no event is raised; while all masks are zero no request writes any memory or raises any event.
- R2: A fast request (valid high, shared low) captured at edge k writes its address and data into every memory t whose mask bit t is set, at edge k+1; evt bit t is high for exactly the one cycle after edge k+1.
- R3: A core whose mask selects its own index writes its own memory like any other target.
- R4: Fast writes from all sixteen cores to sixteen different memories on the same clock all land on the same edge with their own address and data.
- R5: Two fast writes that reach the same memory on the same edge store the OR of their data at the OR of their addresses, and raise that memory's event once.
- R6: The slot counter is 0 out of reset and increments by one each clock, wrapping after 15. A shared write from core c drives its bus only on an edge where the counter holds c, so with the first edge after reset counted as edge 1, the write lands on an edge W with (W - 2 - c) mod 16 = 0, between 1 and 16 edges after capture.
- R7: Shared writes issued on the same edge by all sixteen cores to one memory each land intact at their own address.
- R8: Busy rises after a shared request is captured outside the core's slot and falls on the edge its bus is driven; any request presented while busy is ignored.
- R9: A mask write (mask_we bit c high) loads core c's 16-bit mask at the edge, and the new mask steers every later write.
- R10: rd_data for memory t returns the word at rd_addr for memory t one edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released in step with clk |
| req_valid | input | 16 | Write request, bit c for core c |
| req_shared | input | 16 | Request kind, bit c: 0 fast, 1 shared |
| req_addr | input | 144 | Word address, core c at bits [9c+8:9c] |
| req_data | input | 512 | Write data, core c at bits [32c+31:32c] |
| mask_we | input | 16 | Load enable for core c's target mask |
| mask_val | input | 256 | New mask, core c at bits [16c+15:16c], bit t selects memory t |
| busy | output | 16 | Core c holds an undriven shared write |
| evt | output | 16 | Memory t accepted a write on its second port last edge |
| rd_addr | input | 144 | Read address for memory t at bits [9t+8:9t] |
| rd_data | output | 512 | Registered read data for memory t at bits [32t+31:32t] |

## Verification
Every core writes in fast mode to every memory in turn with a one-hot mask. This separates correct steering from a swapped or shifted mask column, and the diagonal covers the self-target case. A broadcast mask, a rotated permutation in which all cores fire at once, and a deliberate two-writer collision tell real AND-OR merging apart from priority selection or from gating by the wrong bit. Shared-mode runs from single cores at several phases pin the exact landing edge to the slot schedule. A simultaneous request from all sixteen cores into one memory, with a request injected while a core is busy, shows that nothing collides and that a busy core drops new requests.

// File: rtl/lutfab_pkg.sv
package lutfab_pkg;
  localparam int unsigned LF_CORES  = 16;
  localparam int unsigned LF_ADDR_W = 9;
  localparam int unsigned LF_DATA_W = 32;

  typedef enum logic {
    WR_FAST   = 1'b0,
    WR_SHARED = 1'b1
  } wr_mode_e;
endpackage

// File: rtl/lutfab_slot.sv
module lutfab_slot #(
  parameter int unsigned NUM_CORES = 16,
  parameter int unsigned SLOT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_CORES - 1);

  logic [SLOT_W-1:0] slot_q, slot_d;

  always_comb begin
    slot_d = (slot_q == LAST) ? '0 : slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot_o = slot_q;

  assert_slot_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> slot_q == (($past(slot_q) == LAST) ? '0 : $past(slot_q) + 1'b1));
endmodule

// File: rtl/lutfab_core_port.sv
module lutfab_core_port
  import lutfab_pkg::*;
#(
  parameter int unsigned NUM_CORES = 16,
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SLOT_W    = 4,
  parameter int unsigned CORE_IDX  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid_i,
  input  logic                 req_shared_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [DATA_W-1:0]    req_data_i,
  input  logic                 mask_we_i,
  input  logic [NUM_CORES-1:0] mask_val_i,
  input  logic [SLOT_W-1:0]    slot_i,
  output logic                 busy_o,
  output logic [NUM_CORES-1:0] mask_o,
  output logic                 bus_we_o,
  output logic [ADDR_W-1:0]    bus_addr_o,
  output logic [DATA_W-1:0]    bus_data_o
);
  localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(CORE_IDX);

  wr_mode_e mode;
  logic     my_turn, accept;

  logic                 pend_q, pend_d;
  logic [ADDR_W-1:0]    paddr_q, paddr_d;
  logic [DATA_W-1:0]    pdata_q, pdata_d;
  logic                 bwe_q, bwe_d;
  logic                 bsh_q, bsh_d;
  logic [ADDR_W-1:0]    baddr_q, baddr_d;
  logic [DATA_W-1:0]    bdata_q, bdata_d;
  logic [NUM_CORES-1:0] mask_q, mask_d;
  logic                 mask_ce, bus_ce, pend_ce;

  assign mode    = wr_mode_e'(req_shared_i);
  assign my_turn = (slot_i == MY_SLOT);
  assign accept  = req_valid_i & ~pend_q;

  always_comb begin
    pend_d  = pend_q;
    paddr_d = paddr_q;
    pdata_d = pdata_q;
    bwe_d   = 1'b0;
    bsh_d   = 1'b0;
    baddr_d = baddr_q;
    bdata_d = bdata_q;
    bus_ce  = 1'b0;
    pend_ce = 1'b0;
    if (pend_q && my_turn) begin
      bwe_d   = 1'b1;
      bsh_d   = 1'b1;
      baddr_d = paddr_q;
      bdata_d = pdata_q;
      pend_d  = 1'b0;
      bus_ce  = 1'b1;
    end else if (accept) begin
      if (mode == WR_FAST || my_turn) begin
        bwe_d   = 1'b1;
        bsh_d   = (mode == WR_SHARED);
        baddr_d = req_addr_i;
        bdata_d = req_data_i;
        bus_ce  = 1'b1;
      end else begin
        pend_d  = 1'b1;
        paddr_d = req_addr_i;
        pdata_d = req_data_i;
        pend_ce = 1'b1;
      end
    end
    mask_ce = mask_we_i;
    mask_d  = mask_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      bwe_q  <= 1'b0;
      bsh_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      bwe_q  <= bwe_d;
      bsh_q  <= bsh_d;
      if (mask_ce) mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_ce) begin
      paddr_q <= paddr_d;
      pdata_q <= pdata_d;
    end
    if (bus_ce) begin
      baddr_q <= baddr_d;
      bdata_q <= bdata_d;
    end
  end

  assign busy_o     = pend_q;
  assign mask_o     = mask_q;
  assign bus_we_o   = bwe_q;
  assign bus_addr_o = baddr_q;
  assign bus_data_o = bdata_q;

  // Checker state: edges spent waiting for the slot
  logic [SLOT_W:0] wait_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wait_q <= '0;
    else if (pend_q) wait_q <= wait_q + 1'b1;
    else             wait_q <= '0;
  end

  assert_ignored_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && req_valid_i) |=> ($stable(paddr_q) && $stable(pdata_q)));

  assert_shared_in_own_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bwe_q && bsh_q) |-> ($past(slot_i) == MY_SLOT));

  assert_wait_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q <= (SLOT_W+1)'(NUM_CORES - 1));
endmodule

// File: rtl/lutfab_target.sv
module lutfab_target #(
  parameter int unsigned NUM_CORES = 16,
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CORES-1:0]        bus_we_i,
  input  logic [NUM_CORES*ADDR_W-1:0] bus_addr_i,
  input  logic [NUM_CORES*DATA_W-1:0] bus_data_i,
  input  logic [NUM_CORES-1:0]        sel_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic                        evt_o,
  output logic [DATA_W-1:0]           rd_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic              port_we;
  logic [ADDR_W-1:0] port_addr;
  logic [DATA_W-1:0] port_data;
  logic [NUM_CORES-1:0] hit;

  always_comb begin
    port_we   = 1'b0;
    port_addr = '0;
    port_data = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      hit[c]    = bus_we_i[c] & sel_i[c];
      port_we   = port_we | hit[c];
      port_addr = port_addr | (bus_addr_i[c*ADDR_W +: ADDR_W] & {ADDR_W{hit[c]}});
      port_data = port_data | (bus_data_i[c*DATA_W +: DATA_W] & {DATA_W{hit[c]}});
    end
  end

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              evt_q;

  always_ff @(posedge clk) begin
    if (port_we) mem[port_addr] <= port_data;
    rd_q <= mem[rd_addr_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= port_we;
  end

  assign evt_o     = evt_q;
  assign rd_data_o = rd_q;

  assert_event_needs_selected_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> $past(|(bus_we_i & sel_i)));
endmodule

// File: rtl/lutfab_top.sv
module lutfab_top
  import lutfab_pkg::*;
#(
  parameter int unsigned NUM_CORES = LF_CORES,
  parameter int unsigned ADDR_W    = LF_ADDR_W,
  parameter int unsigned DATA_W    = LF_DATA_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CORES-1:0]          req_valid,
  input  logic [NUM_CORES-1:0]          req_shared,
  input  logic [NUM_CORES*ADDR_W-1:0]   req_addr,
  input  logic [NUM_CORES*DATA_W-1:0]   req_data,
  input  logic [NUM_CORES-1:0]          mask_we,
  input  logic [NUM_CORES*NUM_CORES-1:0] mask_val,
  output logic [NUM_CORES-1:0]          busy,
  output logic [NUM_CORES-1:0]          evt,
  input  logic [NUM_CORES*ADDR_W-1:0]   rd_addr,
  output logic [NUM_CORES*DATA_W-1:0]   rd_data
);
  localparam int unsigned SLOT_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [SLOT_W-1:0]           slot;
  logic [NUM_CORES-1:0]        bus_we;
  logic [NUM_CORES*ADDR_W-1:0] bus_addr;
  logic [NUM_CORES*DATA_W-1:0] bus_data;
  logic [NUM_CORES-1:0]        mask_arr [NUM_CORES];
  logic [NUM_CORES-1:0]        sel_col  [NUM_CORES];

  lutfab_slot #(.NUM_CORES(NUM_CORES), .SLOT_W(SLOT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .slot_o(slot)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    lutfab_core_port #(
      .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .SLOT_W(SLOT_W), .CORE_IDX(c)
    ) u_port (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid[c]),
      .req_shared_i (req_shared[c]),
      .req_addr_i   (req_addr[c*ADDR_W +: ADDR_W]),
      .req_data_i   (req_data[c*DATA_W +: DATA_W]),
      .mask_we_i    (mask_we[c]),
      .mask_val_i   (mask_val[c*NUM_CORES +: NUM_CORES]),
      .slot_i       (slot),
      .busy_o       (busy[c]),
      .mask_o       (mask_arr[c]),
      .bus_we_o     (bus_we[c]),
      .bus_addr_o   (bus_addr[c*ADDR_W +: ADDR_W]),
      .bus_data_o   (bus_data[c*DATA_W +: DATA_W])
    );
  end

  for (genvar t = 0; t < NUM_CORES; t++) begin : g_tgt
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_col
      assign sel_col[t][c] = mask_arr[c][t];
    end
    lutfab_target #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tgt (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_we_i   (bus_we),
      .bus_addr_i (bus_addr),
      .bus_data_i (bus_data),
      .sel_i      (sel_col[t]),
      .rd_addr_i  (rd_addr[t*ADDR_W +: ADDR_W]),
      .evt_o      (evt[t]),
      .rd_data_o  (rd_data[t*DATA_W +: DATA_W])
    );
  end

  logic any_mask;
  always_comb begin
    any_mask = 1'b0;
    for (int c = 0; c < NUM_CORES; c++) any_mask = any_mask | (|mask_arr[c]);
  end

  assert_silent_without_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !any_mask |=> (evt == '0));
endmodule

// File: tb/lutfab_top_tb.sv
module lutfab_top_tb;
  localparam int NC = 16;
  localparam int AW = 9;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [NC-1:0]    req_valid, req_shared, mask_we;
  logic [NC*AW-1:0] req_addr, rd_addr;
  logic [NC*DW-1:0] req_data;
  logic [NC*NC-1:0] mask_val;
  logic [NC-1:0]    busy, evt;
  logic [NC*DW-1:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  lutfab_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_shared(req_shared),
    .req_addr(req_addr), .req_data(req_data), .mask_we(mask_we), .mask_val(mask_val),
    .busy(busy), .evt(evt), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic set_mask(input int c, input logic [NC-1:0] m);
    mask_we = '0;
    mask_we[c] = 1'b1;
    mask_val[c*NC +: NC] = m;
    @(negedge clk);
    mask_we = '0;
  endtask

  task automatic clear_masks();
    mask_we  = '1;
    mask_val = '0;
    @(negedge clk);
    mask_we  = '0;
  endtask

  task automatic read_word(input int t, input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_addr[t*AW +: AW] = a;
    @(negedge clk);
    d = rd_data[t*DW +: DW];
  endtask

  function automatic logic [DW-1:0] sweep_data(input int c, input int t);
    return 32'hA500_0000 ^ (c << 12) ^ (t << 4) ^ (c * t);
  endfunction

  // expected landing edge of a shared write from core c captured at edge k
  function automatic int land_edge(input int c, input int k);
    return k + (((c - (k - 1)) % NC + NC) % NC) + 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int k, w;
    int wl [NC];
    rst_n = 1'b0;
    req_valid = '0; req_shared = '0; mask_we = '0;
    req_addr = '0; req_data = '0; mask_val = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and silence with empty masks
    chk(busy == '0, "R1 busy after reset", busy, 0);
    chk(evt == '0, "R1 evt after reset", evt, 0);
    req_valid = '1;
    for (int c = 0; c < NC; c++) req_addr[c*AW +: AW] = AW'(c);
    @(negedge clk);
    req_valid = '0;
    chk(evt == '0, "R1 no event with zero masks (a)", evt, 0);
    @(negedge clk);
    chk(evt == '0, "R1 no event with zero masks (b)", evt, 0);
    @(negedge clk);
    chk(evt == '0, "R1 no event with zero masks (c)", evt, 0);

    // R2 R3 R9: every writer to every target, one-hot masks
    for (int c = 0; c < NC; c++) begin
      for (int t = 0; t < NC; t++) begin
        set_mask(c, NC'(1) << t);
        req_valid[c] = 1'b1;
        req_shared[c] = 1'b0;
        req_addr[c*AW +: AW] = AW'(c*NC + t);
        req_data[c*DW +: DW] = sweep_data(c, t);
        @(negedge clk);
        req_valid[c] = 1'b0;
        @(negedge clk);
        chk(evt == (NC'(1) << t), (c == t) ? "R3 self-target event" : "R2 R9 event at mask target",
            evt, NC'(1) << t);
        @(negedge clk);
        chk(evt == '0, "R2 event lasts one cycle", evt, 0);
        read_word(t, AW'(c*NC + t), d);
        chk(d == sweep_data(c, t), (c == t) ? "R3 R10 self-target word" : "R2 R10 target word",
            d, sweep_data(c, t));
      end
    end
    clear_masks();

    // R2: broadcast from core 5 to all memories
    set_mask(5, '1);
    req_valid[5] = 1'b1;
    req_addr[5*AW +: AW] = 9'h1FF;
    req_data[5*DW +: DW] = 32'h5EED_0005;
    @(negedge clk);
    req_valid[5] = 1'b0;
    @(negedge clk);
    chk(evt == '1, "R2 broadcast events", evt, 16'hFFFF);
    for (int t = 0; t < NC; t++) begin
      read_word(t, 9'h1FF, d);
      chk(d == 32'h5EED_0005, "R2 broadcast word", d, 32'h5EED_0005);
    end
    clear_masks();

    // R4: all cores at once to a rotated set of distinct targets
    mask_we = '1;
    for (int c = 0; c < NC; c++) begin
      mask_val[c*NC +: NC] = NC'(1) << ((c + 3) % NC);
      req_addr[c*AW +: AW] = AW'(9'h120 + c);
      req_data[c*DW +: DW] = 32'hC0DE_0000 | (c << 8) | ((c + 3) % NC);
    end
    @(negedge clk);
    mask_we = '0;
    req_valid = '1;
    req_shared = '0;
    @(negedge clk);
    req_valid = '0;
    @(negedge clk);
    chk(evt == '1, "R4 parallel events same edge", evt, 16'hFFFF);
    for (int c = 0; c < NC; c++) begin
      read_word((c + 3) % NC, AW'(9'h120 + c), d);
      chk(d == (32'hC0DE_0000 | (c << 8) | ((c + 3) % NC)), "R4 parallel word", d,
          32'hC0DE_0000 | (c << 8) | ((c + 3) % NC));
    end
    clear_masks();

    // R5: two fast writers into memory 4 on one edge
    set_mask(2, NC'(1) << 4);
    set_mask(9, NC'(1) << 4);
    req_addr[2*AW +: AW] = 9'h0A1;  req_data[2*DW +: DW] = 32'h00F0_1200;
    req_addr[9*AW +: AW] = 9'h104;  req_data[9*DW +: DW] = 32'h0F00_0034;
    req_valid[2] = 1'b1; req_valid[9] = 1'b1;
    @(negedge clk);
    req_valid = '0;
    @(negedge clk);
    chk(evt == (NC'(1) << 4), "R5 single event on collision", evt, NC'(1) << 4);
    @(negedge clk);
    chk(evt == '0, "R5 event one cycle", evt, 0);
    read_word(4, 9'h1A5, d);
    chk(d == 32'h0FF0_1234, "R5 merged word at merged address", d, 32'h0FF0_1234);
    clear_masks();

    // R6: single-core shared writes at several phases, exact landing edge
    for (int i = 0; i < 6; i++) begin
      int c, t;
      c = (i * 7 + 1) % NC;
      t = (c + 1) % NC;
      set_mask(c, NC'(1) << t);
      repeat (i + 2) @(negedge clk);
      req_valid[c] = 1'b1;
      req_shared[c] = 1'b1;
      req_addr[c*AW +: AW] = AW'(9'h140 + i);
      req_data[c*DW +: DW] = 32'h5A00_0000 | i;
      k = cyc + 1;
      w = land_edge(c, k);
      @(negedge clk);
      req_valid[c] = 1'b0;
      req_shared[c] = 1'b0;
      for (int j = 0; j < 18; j++) begin
        if (evt[t] != (cyc == w))
          chk(1'b0, "R6 shared landing edge", {32'(cyc), 31'b0, evt[t]}, {32'(w), 32'b1});
        @(negedge clk);
      end
      chk(1'b1, "R6 shared landing edge", 0, 0);
      read_word(t, AW'(9'h140 + i), d);
      chk(d == (32'h5A00_0000 | i), "R6 shared word", d, 32'h5A00_0000 | i);
      set_mask(c, '0);
    end

    // R7 R8: all sixteen cores share into memory 7 at once
    set_mask(0, NC'(1) << 7);
    req_valid[0] = 1'b1;
    req_addr[0*AW +: AW] = 9'h1F0;
    req_data[0*DW +: DW] = 32'h0BAD_F00D;
    @(negedge clk);
    req_valid = '0;
    repeat (2) @(negedge clk);
    mask_we = '1;
    for (int c = 0; c < NC; c++) begin
      mask_val[c*NC +: NC] = NC'(1) << 7;
      req_addr[c*AW +: AW] = AW'(9'h100 + c);
      req_data[c*DW +: DW] = 32'h7700_0000 | (c * 32'h0001_0101);
    end
    @(negedge clk);
    mask_we = '0;
    req_valid = '1;
    req_shared = '1;
    k = cyc + 1;
    for (int c = 0; c < NC; c++) wl[c] = land_edge(c, k);
    @(negedge clk);
    req_valid = '0;
    req_shared = '0;
    for (int c = 0; c < NC; c++)
      chk(busy[c] == (wl[c] != k + 1), "R8 busy after capture", busy[c], wl[c] != k + 1);
    begin
      int d_core;
      d_core = (k + 14) % NC;
      req_valid[d_core] = 1'b1;
      req_addr[d_core*AW +: AW] = 9'h1F0;
      req_data[d_core*DW +: DW] = 32'hDEAD_BEEF;
      for (int j = 0; j < 18; j++) begin
        bit exp_e;
        exp_e = 1'b0;
        for (int c = 0; c < NC; c++) if (wl[c] == cyc) exp_e = 1'b1;
        if (evt[7] != exp_e) chk(1'b0, "R7 event sequence", evt[7], exp_e);
        @(negedge clk);
        req_valid = '0;
      end
      chk(1'b1, "R7 event sequence", 0, 0);
    end
    chk(busy == '0, "R8 busy cleared after drain", busy, 0);
    for (int c = 0; c < NC; c++) begin
      read_word(7, AW'(9'h100 + c), d);
      chk(d == (32'h7700_0000 | (c * 32'h0001_0101)), "R7 shared word intact", d,
          32'h7700_0000 | (c * 32'h0001_0101));
    end
    read_word(7, 9'h1F0, d);
    chk(d == 32'h0BAD_F00D, "R8 request while busy ignored", d, 32'h0BAD_F00D);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule